// File: doc/BRIEF.md
# Multi-format audio serial transmitter

This block moves parallel audio words from a transmit queue onto a single serial data line. It does not make its own serial timing. It samples an external bit clock and an external frame-sync line on its system clock. It turns each bit-clock transition on the chosen edge into a one-cycle launch strobe, and it drives one data bit per strobe, MSB first. A packed control word selects the framing at run time. The choices are standard I2S, left-justified, right-justified, or a short-pulse PCM frame with a 0 to 3 bit delay. The same word also sets the sample width, the channel count and which bit-clock edge launches data.

A five-state sequencer drives the shifter. IDLE waits for the first frame boundary after start is raised. LEAD counts the bit slots between the boundary and the first word. SHIFT sends words back to back and takes one queue item at each word start. GAP sends zeros until the next boundary. CLR holds everything for a fixed number of cycles after a clear pulse. These transitions are possible:
- IDLE, LEAD, SHIFT or GAP go to LEAD or SHIFT on a boundary, depending on the lead.
- LEAD goes to SHIFT when its count runs out.
- SHIFT goes to SHIFT (next word) or to GAP (last word done).
- Any state goes to IDLE when start falls.
- Any state goes to CLR on clear, and CLR goes to IDLE when its count expires.

The half-frame length in bit clocks is the parameter HALF_BITS. The PCM frame is twice that length. The system clock must run at least eight times faster than the bit clock. The bit clock and frame sync are expected to be synchronous to the system clock already.

Top module: `audio_ser_tx`

## Requirements
- R1: After reset, sdo, underrun, clear_busy and tx_pop are all 0.
- R2: The launch edge of bclk is selected by ctrl[11]. When ctrl[11]=0, sdo changes only after a falling edge. When ctrl[11]=1, sdo changes only after a rising edge. Between launches sdo holds its value, so it is stable at the opposite edge.
- R3: Framing is chosen by ctrl[10:9] and ctrl[5]. With ctrl[5]=0 and ctrl[10:9]=0 (standard), each half frame starts at the launch edge where fsync has changed level. The MSB of the first word goes out at bit slot 1 of that half, and data is sent MSB first.
- R4: With ctrl[5]=0 and ctrl[10:9]=1 (left-justified), the MSB of the first word goes out at bit slot 0 of the half, the slot of the fsync change. Code 3 behaves the same way.
- R5: With ctrl[5]=0 and ctrl[10:9]=2 (right-justified), the words of a half are packed against its end. The LSB of the last word occupies slot HALF_BITS-1, so the first MSB is at slot HALF_BITS minus (words × width).
- R6: With ctrl[5]=1 (PCM), a frame starts at the launch edge where fsync is first seen high. The first MSB follows ctrl[8:7] bit slots later (0 to 3). All words of the frame then follow back to back.
- R7: The sample width is ctrl[4:0]+1 bits. The low bits of tx_data carry the sample, and any tx_data bits above the width are not sent.
- R8: ctrl[16:15]=c selects 2(c+1) channels. A standard, left- or right-justified half carries c+1 words, and a PCM frame carries 2(c+1) words, all back to back. Every other bit slot carries 0.
- R9: One queue item is taken per word, at the word's first bit. tx_pop is a one-cycle pulse in the next cycle and occurs only if tx_valid was high.
- R10: If tx_valid is low at a word start, that word is sent as all zeros and underrun goes to 1. Underrun stays at 1 until a clear.
- R11: While start is 0, sdo is 0 and no item is taken. After start rises, output begins only at the next frame boundary.
- R12: A clear pulse raises clear_busy from the next cycle for CLR_CYCLES cycles. It resets underrun and returns the sequencer to IDLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| bclk | input | 1 | Bit clock, sampled on clk |
| fsync | input | 1 | Frame sync / channel select, sampled at launch edges |
| ctrl | input | 17 | Packed framing, width, channel and polarity control |
| start | input | 1 | Enables shifting while high |
| clear | input | 1 | One-cycle clear request |
| tx_valid | input | 1 | Queue head is valid |
| tx_data | input | DW | Queue head sample, right-aligned |
| tx_pop | output | 1 | Pulse: queue head was taken |
| sdo | output | 1 | Serial data out |
| underrun | output | 1 | Sticky: a word was sent without a sample |
| clear_busy | output | 1 | High while a clear is in progress |

## Verification
The bench drives the bit clock and frame sync itself and captures every bit slot. It rebuilds each expected half or frame from the slot rules: words at offsets 1, 0, or end-aligned, and in PCM at the programmed delay. Any slip of one slot, a wrong justification or a word not zero-filled shows up as a mismatch in both the word and the fill check. The samples carry set bits above the selected width, which separates a masked load from a raw one. Runs with two, four and eight channels separate back-to-back packing from per-half restarts, and PCM delays 0, 1 and 3 distinguish the lead count. Stopped, starved and cleared runs check the zero output, the consumption count and the sticky flag against each other.

// File: rtl/audio_ser_tx_pkg.sv
package audio_ser_tx_pkg;

    localparam int CTRL_W = 17;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_SHIFT,
        ST_GAP,
        ST_CLR
    } seq_state_e;

    typedef enum logic [1:0] {
        OP_HOLD,
        OP_ZERO,
        OP_LOAD,
        OP_SHIFT
    } shift_op_e;

    typedef struct packed {
        logic [1:0] chan;
        logic       inv;
        logic [1:0] just;
        logic [1:0] dly;
        logic       pcm;
        logic [4:0] wm1;
    } tx_cfg_t;

    function automatic tx_cfg_t decode_ctrl(input logic [CTRL_W-1:0] w);
        tx_cfg_t c;
        c.chan = w[16:15];
        c.inv  = w[11];
        c.just = w[10:9];
        c.dly  = w[8:7];
        c.pcm  = w[5];
        c.wm1  = w[4:0];
        return c;
    endfunction

endpackage

// File: rtl/audio_ser_tx_edges.sv
module audio_ser_tx_edges (
    input  logic clk,
    input  logic rst_n,
    input  logic bclk,
    input  logic fsync,
    input  logic inv,
    input  logic pcm,
    output logic launch,
    output logic boundary
);

    logic bclk_q;
    logic fs_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bclk_q <= 1'b1;
            fs_q   <= 1'b0;
        end else begin
            bclk_q <= bclk;
            if (launch) fs_q <= fsync;
        end
    end

    always_comb begin
        // Launch edge: bclk leaves its capture level (falling when inv=0).
        launch   = (bclk_q ^ inv) & ~(bclk ^ inv);
        boundary = launch & (pcm ? (fsync & ~fs_q) : (fsync ^ fs_q));
    end

endmodule

// File: rtl/audio_ser_tx_seq.sv
module audio_ser_tx_seq
    import audio_ser_tx_pkg::*;
#(
    parameter int LW         = 6,
    parameter int CLR_CYCLES = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          launch,
    input  logic          boundary,
    input  logic          start,
    input  logic          clear,
    input  logic          src_valid,
    input  logic [3:0]    seg_words,
    input  logic [LW-1:0] lead,
    input  logic [4:0]    wm1,
    output shift_op_e     op,
    output logic          tx_pop,
    output logic          underrun,
    output logic          clear_busy
);

    localparam int CW = (CLR_CYCLES > 1) ? $clog2(CLR_CYCLES) : 1;

    seq_state_e    state, nxt;
    logic [3:0]    wcnt, nwc;
    logic [4:0]    bcnt, nbc;
    logic [LW-1:0] dcnt, ndc;
    logic [CW-1:0] ccnt, ncc;
    logic          take;
    logic          word_go;

    // Next-state and shifter command.
    always_comb begin
        nxt     = state;
        nwc     = wcnt;
        nbc     = bcnt;
        ndc     = dcnt;
        ncc     = ccnt;
        op      = OP_HOLD;
        take    = 1'b0;
        word_go = 1'b0;
        if (clear) begin
            nxt = ST_CLR;
            ncc = CW'(CLR_CYCLES - 1);
            op  = OP_ZERO;
        end else if (state == ST_CLR) begin
            op = OP_ZERO;
            if (ccnt == '0) nxt = ST_IDLE;
            else            ncc = ccnt - 1'b1;
        end else if (!start) begin
            nxt = ST_IDLE;
            op  = OP_ZERO;
        end else if (launch) begin
            if (boundary) begin
                nwc = '0;
                if (lead == '0) begin
                    word_go = 1'b1;
                end else begin
                    nxt = ST_LEAD;
                    ndc = lead - 1'b1;
                    op  = OP_ZERO;
                end
            end else begin
                unique case (state)
                    ST_LEAD: begin
                        if (dcnt == '0) word_go = 1'b1;
                        else begin
                            ndc = dcnt - 1'b1;
                            op  = OP_ZERO;
                        end
                    end
                    ST_SHIFT: begin
                        if (bcnt != '0) begin
                            op  = OP_SHIFT;
                            nbc = bcnt - 1'b1;
                        end else if ((wcnt + 4'd1) < seg_words) begin
                            nwc     = wcnt + 4'd1;
                            word_go = 1'b1;
                        end else begin
                            nxt = ST_GAP;
                            op  = OP_ZERO;
                        end
                    end
                    default: op = OP_ZERO;
                endcase
            end
            if (word_go) begin
                nxt  = ST_SHIFT;
                nbc  = wm1;
                op   = OP_LOAD;
                take = src_valid;
            end
        end
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            wcnt  <= '0;
            bcnt  <= '0;
            dcnt  <= '0;
            ccnt  <= '0;
        end else begin
            state <= nxt;
            wcnt  <= nwc;
            bcnt  <= nbc;
            dcnt  <= ndc;
            ccnt  <= ncc;
        end
    end

    // Registered outputs.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_pop   <= 1'b0;
            underrun <= 1'b0;
        end else begin
            tx_pop <= take;
            if (clear)                     underrun <= 1'b0;
            else if (word_go && !src_valid) underrun <= 1'b1;
        end
    end

    assign clear_busy = (state == ST_CLR);

endmodule

// File: rtl/audio_ser_tx_shift.sv
module audio_ser_tx_shift
    import audio_ser_tx_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  shift_op_e     op,
    input  logic          in_valid,
    input  logic [DW-1:0] data,
    input  logic [4:0]    wm1,
    output logic          sdo
);

    logic [DW-1:0] shreg;
    logic [DW-1:0] fresh;

    // MSB of the selected width lands in the top bit; wider bits fall off.
    always_comb fresh = in_valid ? (data << (DW - 1 - int'(wm1))) : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg <= '0;
            sdo   <= 1'b0;
        end else begin
            unique case (op)
                OP_LOAD: begin
                    sdo   <= fresh[DW-1];
                    shreg <= fresh << 1;
                end
                OP_SHIFT: begin
                    sdo   <= shreg[DW-1];
                    shreg <= shreg << 1;
                end
                OP_ZERO: sdo <= 1'b0;
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/audio_ser_tx.sv
module audio_ser_tx
    import audio_ser_tx_pkg::*;
#(
    parameter int DW         = 32,
    parameter int HALF_BITS  = 32,
    parameter int CLR_CYCLES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bclk,
    input  logic              fsync,
    input  logic [CTRL_W-1:0] ctrl,
    input  logic              start,
    input  logic              clear,
    input  logic              tx_valid,
    input  logic [DW-1:0]     tx_data,
    output logic              tx_pop,
    output logic              sdo,
    output logic              underrun,
    output logic              clear_busy
);

    localparam int LW = $clog2(HALF_BITS + 1);

    tx_cfg_t       cfg;
    logic          launch;
    logic          boundary;
    logic [3:0]    seg_words;
    logic [LW-1:0] lead;
    int            span;
    shift_op_e     op;

    always_comb begin
        cfg       = decode_ctrl(ctrl);
        seg_words = cfg.pcm ? {{1'b0, cfg.chan} + 3'd1, 1'b0}
                            : {1'b0, {1'b0, cfg.chan} + 3'd1};
        span      = int'(seg_words) * (int'(cfg.wm1) + 1);
        if (cfg.pcm)               lead = LW'(cfg.dly);
        else if (cfg.just == 2'd0) lead = LW'(1);
        else if (cfg.just == 2'd2) lead = (span >= HALF_BITS) ? '0 : LW'(HALF_BITS - span);
        else                       lead = '0;
    end

    audio_ser_tx_edges u_edges (
        .clk      (clk),
        .rst_n    (rst_n),
        .bclk     (bclk),
        .fsync    (fsync),
        .inv      (cfg.inv),
        .pcm      (cfg.pcm),
        .launch   (launch),
        .boundary (boundary)
    );

    audio_ser_tx_seq #(
        .LW         (LW),
        .CLR_CYCLES (CLR_CYCLES)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .launch     (launch),
        .boundary   (boundary),
        .start      (start),
        .clear      (clear),
        .src_valid  (tx_valid),
        .seg_words  (seg_words),
        .lead       (lead),
        .wm1        (cfg.wm1),
        .op         (op),
        .tx_pop     (tx_pop),
        .underrun   (underrun),
        .clear_busy (clear_busy)
    );

    audio_ser_tx_shift #(
        .DW (DW)
    ) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .op       (op),
        .in_valid (tx_valid),
        .data     (tx_data),
        .wm1      (cfg.wm1),
        .sdo      (sdo)
    );

endmodule

// File: rtl/audio_ser_tx_chk.sv
module audio_ser_tx_chk (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic clear,
    input logic tx_valid,
    input logic tx_pop,
    input logic sdo,
    input logic underrun,
    input logic clear_busy,
    input logic launch
);

    p_sdo_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!launch && start && !clear && !clear_busy) |=> $stable(sdo));

    p_pop_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        tx_pop |=> !tx_pop);

    p_pop_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
        tx_pop |-> $past(tx_valid));

    p_underrun_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (underrun && !clear) |=> underrun);

    p_underrun_at_launch_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(underrun) |-> $past(launch));

    p_stop_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> (!sdo && !tx_pop));

    p_clear_flag_r12: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (clear_busy && !underrun));

endmodule

bind audio_ser_tx audio_ser_tx_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .clear      (clear),
    .tx_valid   (tx_valid),
    .tx_pop     (tx_pop),
    .sdo        (sdo),
    .underrun   (underrun),
    .clear_busy (clear_busy),
    .launch     (launch)
);

// File: tb/audio_ser_tx_bench.sv
module audio_ser_tx_bench;

    localparam int HALF = 32;
    localparam int CLRN = 4;

    logic        clk = 1'b0;
    logic        rst_n, bclk, fsync, start, clear, tx_valid;
    logic [16:0] ctrl;
    logic [31:0] tx_data;
    logic        tx_pop, sdo, underrun, clear_busy;

    int n_tests = 0, n_fail = 0, pop_cnt = 0;
    bit done = 0;
    logic [31:0] src_q[$];
    logic [31:0] exp_q[$];

    logic [1:0] cur_just, cur_dly;
    logic       cur_pcm, inv_b;
    int         cur_w, cur_nw;
    bit         expect_on = 1;
    string      cur_tag = "R3";

    always #4 clk = ~clk;

    audio_ser_tx #(.DW(32), .HALF_BITS(HALF), .CLR_CYCLES(CLRN)) u_audio_ser_tx (
        .clk(clk), .rst_n(rst_n), .bclk(bclk), .fsync(fsync), .ctrl(ctrl),
        .start(start), .clear(clear), .tx_valid(tx_valid), .tx_data(tx_data),
        .tx_pop(tx_pop), .sdo(sdo), .underrun(underrun), .clear_busy(clear_busy));

    task automatic check(input bit ok, input string req, input string what,
                         input logic [127:0] act, input logic [127:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Queue model feeding the design.
    initial begin
        tx_valid = 1'b0;
        tx_data  = '0;
        forever begin
            @(negedge clk);
            if (tx_pop && src_q.size() > 0) begin
                src_q.delete(0);
                pop_cnt++;
            end
            tx_valid = (src_q.size() > 0);
            tx_data  = tx_valid ? src_q[0] : '0;
        end
    end

    // Driver: one item to the source, its masked image to the scoreboard.
    task automatic push_sample(input logic [31:0] v);
        logic [63:0] m;
        m = (64'd1 << cur_w) - 64'd1;
        src_q.push_back(v);
        exp_q.push_back(v & m[31:0]);
    endtask

    task automatic bit_slot(input logic fsv, output logic b, output logic steady);
        bclk  = inv_b;
        fsync = fsv;
        repeat (4) @(negedge clk);
        b    = sdo;
        bclk = ~inv_b;
        repeat (4) @(negedge clk);
        steady = (sdo == b);
    endtask

    task automatic set_mode(input logic [1:0] just, input logic pcm, input logic [1:0] dly,
                            input int w, input logic [1:0] ch, input logic iv, input string tag);
        logic b, st;
        start    = 1'b0;
        cur_just = just; cur_pcm = pcm; cur_dly = dly; cur_w = w; inv_b = iv; cur_tag = tag;
        cur_nw   = pcm ? 2 * (int'(ch) + 1) : int'(ch) + 1;
        ctrl     = {ch, 3'b000, iv, just, dly, 1'b0, pcm, 5'(w - 1)};
        bclk     = ~iv;
        repeat (2) @(negedge clk);
        for (int i = 0; i < 2; i++) bit_slot(pcm ? 1'b0 : 1'b1, b, st);
        start = 1'b1;
    endtask

    // Monitor: captures a half or a frame and compares it with the scoreboard.
    task automatic segment(input int len, input logic hv);
        logic [0:127] got, want;
        logic b, st;
        int bad = 0;
        int base;
        got = '0; want = '0;
        for (int p = 0; p < len; p++) begin
            bit_slot(cur_pcm ? (p == 0) : hv, b, st);
            got[p] = b;
            if (!st) bad++;
        end
        if (cur_pcm)              base = int'(cur_dly);
        else if (cur_just == 2'd0) base = 1;
        else if (cur_just == 2'd2) base = HALF - cur_nw * cur_w;
        else                       base = 0;
        if (expect_on) begin
            for (int k = 0; k < cur_nw; k++) begin
                logic [31:0] e, a;
                e = (exp_q.size() > 0) ? exp_q.pop_front() : '0;
                a = '0;
                for (int i = 0; i < cur_w; i++) begin
                    a = {a[30:0], got[base + k * cur_w + i]};
                    want[base + k * cur_w + i] = e[cur_w - 1 - i];
                end
                check(a == e, cur_tag, "word", 128'(a), 128'(e));
            end
        end
        check(got == want, expect_on ? "R8" : "R11", "slot fill", got, want);
        check(bad == 0, "R2", "sdo held to capture edge", 128'(bad), 128'(0));
    endtask

    task automatic run_frames(input int n);
        repeat (2) @(negedge clk);
        for (int f = 0; f < n; f++) begin
            if (cur_pcm) segment(2 * HALF, 1'b0);
            else begin
                segment(HALF, 1'b0);
                segment(HALF, 1'b1);
            end
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int p0;
        rst_n = 1'b0; start = 1'b0; clear = 1'b0; ctrl = '0; bclk = 1'b1; fsync = 1'b1;
        inv_b = 1'b0; cur_w = 16;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check({sdo, underrun, clear_busy, tx_pop} == 4'b0, "R1", "reset outputs",
              128'({sdo, underrun, clear_busy, tx_pop}), 128'(0));

        // R3 standard, 16-bit, upper bits set to show masking (R7), R9 count
        set_mode(2'd0, 1'b0, 2'd0, 16, 2'd0, 1'b0, "R3");
        p0 = pop_cnt;
        push_sample(32'hABCD_8001); push_sample(32'h1234_5AA5);
        push_sample(32'hFFFF_0F0F); push_sample(32'h0000_C3FF);
        run_frames(2);
        check(pop_cnt - p0 == 4, "R9", "items taken", 128'(pop_cnt - p0), 128'(4));
        check(underrun == 1'b0, "R10", "no underrun when fed", 128'(underrun), 128'(0));

        // R4 left-justified, 24-bit (R7)
        set_mode(2'd1, 1'b0, 2'd0, 24, 2'd0, 1'b0, "R4");
        push_sample(32'h5A_C0FFEE); push_sample(32'hFF_800001);
        run_frames(1);

        // R5 right-justified, 16-bit and 4-channel 12-bit
        set_mode(2'd2, 1'b0, 2'd0, 16, 2'd0, 1'b0, "R5");
        push_sample(32'h0000_9E37); push_sample(32'h7777_0001);
        run_frames(1);
        set_mode(2'd2, 1'b0, 2'd0, 12, 2'd1, 1'b0, "R5");
        for (int i = 0; i < 4; i++) push_sample(32'hF000_0A5C + 32'(i * 97));
        run_frames(1);

        // R8 eight channels, left-justified 8-bit fills every slot
        set_mode(2'd1, 1'b0, 2'd0, 8, 2'd3, 1'b0, "R8");
        for (int i = 0; i < 8; i++) push_sample(32'h0000_0081 + 32'(i * 19));
        run_frames(1);

        // R6 PCM frames with delays 1 and 3, then eight channels at delay 0
        set_mode(2'd0, 1'b1, 2'd1, 16, 2'd0, 1'b0, "R6");
        push_sample(32'h0000_F00D); push_sample(32'h0000_8421);
        run_frames(1);
        set_mode(2'd0, 1'b1, 2'd3, 16, 2'd0, 1'b0, "R6");
        push_sample(32'h0000_B00B); push_sample(32'h0000_0003);
        run_frames(1);
        set_mode(2'd0, 1'b1, 2'd0, 8, 2'd3, 1'b0, "R6");
        for (int i = 0; i < 8; i++) push_sample(32'h0000_00E1 - 32'(i * 23));
        run_frames(1);

        // R2 inverted launch edge
        set_mode(2'd0, 1'b0, 2'd0, 16, 2'd0, 1'b1, "R2");
        push_sample(32'h0000_D1CE); push_sample(32'h0000_2B2B);
        run_frames(1);

        // R11 stopped: nothing sent, nothing taken, then resumes at a boundary
        set_mode(2'd0, 1'b0, 2'd0, 16, 2'd0, 1'b0, "R11");
        start = 1'b0;
        p0 = pop_cnt;
        push_sample(32'h0000_6E6E); push_sample(32'h0000_9119);
        expect_on = 0;
        run_frames(1);
        check(pop_cnt == p0, "R11", "items taken while stopped", 128'(pop_cnt - p0), 128'(0));
        expect_on = 1;
        start = 1'b1;
        run_frames(1);
        check(pop_cnt - p0 == 2, "R11", "items taken after restart", 128'(pop_cnt - p0), 128'(2));

        // R10 starved frame sends zeros and sets the sticky flag
        cur_tag = "R10";
        run_frames(1);
        check(underrun == 1'b1, "R10", "underrun flag", 128'(underrun), 128'(1));
        start = 1'b0;
        repeat (3) @(negedge clk);
        check(underrun == 1'b1, "R10", "underrun sticky", 128'(underrun), 128'(1));

        // R12 clear timing and flag reset
        clear = 1'b1;
        @(negedge clk);
        clear = 1'b0;
        check(clear_busy == 1'b1, "R12", "busy after clear", 128'(clear_busy), 128'(1));
        check(underrun == 1'b0, "R12", "underrun cleared", 128'(underrun), 128'(0));
        repeat (CLRN - 1) @(negedge clk);
        check(clear_busy == 1'b1, "R12", "busy in last cycle", 128'(clear_busy), 128'(1));
        @(negedge clk);
        check(clear_busy == 1'b0, "R12", "busy released", 128'(clear_busy), 128'(0));

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule